// File: doc/BRIEF.md
# Trace Filter Dual Comparator

This block is one comparator of a trace filtering subsystem. On every clock it picks a primary and a secondary operand from four hart buses: instruction address, execution context, trap value and data address. It tests each operand against its own programmable reference value with a relational function. It then folds the two results into a single comparator match bit, under one of four combining modes. One of these modes is a sticky range mode: the match bit turns on at a primary hit and stays on until the secondary side hits.

The secondary function has one special setting. In that setting the secondary reference stops acting as a compare value and becomes a bit mask on both sides of the primary compare. The block also drives two notify strobes, one for each side. A filter or packet generator uses them to report watchpoint hits on instruction addresses. Configuration arrives as plain static inputs. Every output is registered, so results appear one clock after the inputs that cause them.

Top module: `trace_addr_cmp`

## Requirements
- R1: Each side's 2-bit input select picks 0 = instruction address, 1 = context, 2 = trap value, 3 = data address. A narrower bus is zero-extended to the reference width before the compare.
- R2: Function codes 0..5 test the selected operand against the reference as unsigned equal, not equal, less than, less or equal, greater than and greater or equal, in that order.
- R3: Primary function 6 and 7 always hit, and secondary function 7 always hits.
- R4: With secondary function 6, the primary compare is made between (operand AND secondary reference) and (primary reference AND secondary reference), and the secondary result always hits.
- R5: In mode 0 the match bit equals the primary result.
- R6: In mode 1 the match bit is primary AND secondary.
- R7: In mode 2 the match bit is NOT (primary AND secondary).
- R8: In mode 3 a primary hit starts a held match. The match bit is set in every cycle with a primary hit or a held match, including the cycle of the secondary hit. The hold ends after that cycle.
- R9: A notify strobe of a side fires when that side's notify enable is set, that side hits and that side's select is 0 (instruction address). Otherwise it stays low.
- R10: While enable is low, all three outputs go low and the mode 3 hold is cleared.
- R11: All outputs are registered, with one cycle of latency from the inputs, and read 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Comparator enable; low clears outputs and hold |
| priSel | input | 2 | Primary operand select |
| secSel | input | 2 | Secondary operand select |
| priFunc | input | 3 | Primary relational function |
| secFunc | input | 3 | Secondary relational function (6 = mask) |
| matchMode | input | 2 | Combining mode |
| priValue | input | MATCH_W | Primary reference value |
| secValue | input | MATCH_W | Secondary reference value or mask |
| priNotifyEn | input | 1 | Enable the primary notify strobe |
| secNotifyEn | input | 1 | Enable the secondary notify strobe |
| iaddr | input | IADDR_W | Instruction address bus |
| ctxIn | input | CTX_W | Context bus |
| tvalIn | input | TVAL_W | Trap value bus |
| daddr | input | DADDR_W | Data address bus |
| matchOut | output | 1 | Comparator match bit |
| priNotify | output | 1 | Primary watchpoint strobe |
| secNotify | output | 1 | Secondary watchpoint strobe |

## Verification
The match bit and both notify strobes are due exactly one clock after the bus values and configuration that produce them. The mode 3 hold affects the match bit one cycle after the primary hit that sets it. The driver applies each stimulus on a falling edge and queues the expected triple. The monitor checks the oldest queued entry shortly after the next rising edge, so each stimulus is matched with the cycle in which its result is registered. Configuration changes are staged in shadow variables and applied only on the driving edge, so an in-flight expectation never sees them.

// File: rtl/trcmp_pkg.sv
package trcmp_pkg;

  typedef enum logic [1:0] {
    SEL_IADDR = 2'd0,
    SEL_CTX   = 2'd1,
    SEL_TVAL  = 2'd2,
    SEL_DADDR = 2'd3
  } busSel_e;

  typedef enum logic [2:0] {
    FN_EQ      = 3'd0,
    FN_NE      = 3'd1,
    FN_LT      = 3'd2,
    FN_LE      = 3'd3,
    FN_GT      = 3'd4,
    FN_GE      = 3'd5,
    FN_SPECIAL = 3'd6,
    FN_ALWAYS  = 3'd7
  } cmpFunc_e;

  typedef enum logic [1:0] {
    MODE_PRI   = 2'd0,
    MODE_BOTH  = 2'd1,
    MODE_NAND  = 2'd2,
    MODE_RANGE = 2'd3
  } matchMode_e;

  // Strobes handed from datapath to control every cycle
  typedef struct packed {
    logic priHit;
    logic secHit;
  } cmpStrobe_t;

  localparam int NUM_SIDES = 2;
  localparam int NUM_BUSES = 4;

endpackage

// File: rtl/trcmp_relop.sv
module trcmp_relop #(
  parameter int W = 32
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  logic [2:0]   func,
  output logic         hit
);
  import trcmp_pkg::*;

  always_comb begin
    unique case (cmpFunc_e'(func))
      FN_EQ:   hit = (lhs == rhs);
      FN_NE:   hit = (lhs != rhs);
      FN_LT:   hit = (lhs <  rhs);
      FN_LE:   hit = (lhs <= rhs);
      FN_GT:   hit = (lhs >  rhs);
      FN_GE:   hit = (lhs >= rhs);
      default: hit = 1'b1;  // 6 and 7: unconditional
    endcase
  end

endmodule

// File: rtl/trcmp_datapath.sv
module trcmp_datapath #(
  parameter int IADDR_W = 32,
  parameter int CTX_W   = 24,
  parameter int TVAL_W  = 32,
  parameter int DADDR_W = 32,
  parameter int MATCH_W = 32
) (
  input  logic [IADDR_W-1:0] iaddr,
  input  logic [CTX_W-1:0]   ctxIn,
  input  logic [TVAL_W-1:0]  tvalIn,
  input  logic [DADDR_W-1:0] daddr,
  input  logic [1:0]         priSel,
  input  logic [1:0]         secSel,
  input  logic [2:0]         priFunc,
  input  logic [2:0]         secFunc,
  input  logic [MATCH_W-1:0] priValue,
  input  logic [MATCH_W-1:0] secValue,
  output trcmp_pkg::cmpStrobe_t strobe
);
  import trcmp_pkg::*;

  logic [MATCH_W-1:0] busList [NUM_BUSES];
  logic [1:0]         selArr  [NUM_SIDES];
  logic [2:0]         fnArr   [NUM_SIDES];
  logic [MATCH_W-1:0] refArr  [NUM_SIDES];
  logic [MATCH_W-1:0] maskArr [NUM_SIDES];
  logic [MATCH_W-1:0] lhsArr  [NUM_SIDES];
  logic [MATCH_W-1:0] rhsArr  [NUM_SIDES];
  logic               hitArr  [NUM_SIDES];
  logic               maskMode;

  // Size casts zero-extend narrow buses and trim wider ones
  assign busList[SEL_IADDR] = MATCH_W'(iaddr);
  assign busList[SEL_CTX]   = MATCH_W'(ctxIn);
  assign busList[SEL_TVAL]  = MATCH_W'(tvalIn);
  assign busList[SEL_DADDR] = MATCH_W'(daddr);

  assign maskMode = (secFunc == FN_SPECIAL);

  assign selArr[0]  = priSel;
  assign selArr[1]  = secSel;
  assign fnArr[0]   = priFunc;
  assign fnArr[1]   = secFunc;
  assign refArr[0]  = priValue;
  assign refArr[1]  = secValue;
  assign maskArr[0] = maskMode ? secValue : {MATCH_W{1'b1}};
  assign maskArr[1] = {MATCH_W{1'b1}};

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    assign lhsArr[s] = busList[selArr[s]] & maskArr[s];
    assign rhsArr[s] = refArr[s] & maskArr[s];
    trcmp_relop #(.W(MATCH_W)) u_relop (
      .lhs  (lhsArr[s]),
      .rhs  (rhsArr[s]),
      .func (fnArr[s]),
      .hit  (hitArr[s])
    );
  end

  assign strobe.priHit = hitArr[0];
  assign strobe.secHit = hitArr[1];

  // R3 / R4: unconditional codes must reach the strobes as hits
  always_comb begin
    if (priFunc == FN_ALWAYS || priFunc == FN_SPECIAL)
      a_r3_pri_always: assert (strobe.priHit);
    if (secFunc == FN_ALWAYS)
      a_r3_sec_always: assert (strobe.secHit);
    if (secFunc == FN_SPECIAL)
      a_r4_mask_sec_hit: assert (strobe.secHit);
  end

endmodule

// File: rtl/trcmp_ctrl.sv
module trcmp_ctrl (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enable,
  input  logic [1:0]            matchMode,
  input  logic [1:0]            priSel,
  input  logic [1:0]            secSel,
  input  logic                  priNotifyEn,
  input  logic                  secNotifyEn,
  input  trcmp_pkg::cmpStrobe_t strobe,
  output logic                  matchOut,
  output logic                  priNotify,
  output logic                  secNotify
);
  import trcmp_pkg::*;

  logic holdQ, holdD;
  logic matchQ, matchD;
  logic priNotQ, priNotD;
  logic secNotQ, secNotD;
  logic rangeMode;

  assign rangeMode = (matchMode == MODE_RANGE);

  always_comb begin
    unique case (matchMode_e'(matchMode))
      MODE_PRI:   matchD = strobe.priHit;
      MODE_BOTH:  matchD = strobe.priHit && strobe.secHit;
      MODE_NAND:  matchD = !(strobe.priHit && strobe.secHit);
      default:    matchD = strobe.priHit || holdQ;
    endcase
    matchD  = matchD && enable;
    holdD   = enable && rangeMode && (strobe.priHit || holdQ) && !strobe.secHit;
    priNotD = enable && priNotifyEn && strobe.priHit && (priSel == SEL_IADDR);
    secNotD = enable && secNotifyEn && strobe.secHit && (secSel == SEL_IADDR);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdQ   <= 1'b0;
      matchQ  <= 1'b0;
      priNotQ <= 1'b0;
      secNotQ <= 1'b0;
    end else begin
      holdQ   <= holdD;
      matchQ  <= matchD;
      priNotQ <= priNotD;
      secNotQ <= secNotD;
    end
  end

  assign matchOut  = matchQ;
  assign priNotify = priNotQ;
  assign secNotify = secNotQ;

  a_r5_mode_pri: assert property (@(posedge clk) disable iff (!rstN)
    (enable && matchMode == 2'd0) |=> (matchOut == $past(strobe.priHit)));

  a_r6_mode_both: assert property (@(posedge clk) disable iff (!rstN)
    (enable && matchMode == 2'd1) |=> (matchOut == $past(strobe.priHit && strobe.secHit)));

  a_r7_mode_nand: assert property (@(posedge clk) disable iff (!rstN)
    (enable && matchMode == 2'd2) |=> (matchOut == !$past(strobe.priHit && strobe.secHit)));

  a_r8_hold_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (enable && rangeMode && holdQ && !strobe.secHit) |=> (matchOut && holdQ));

  a_r8_sec_releases: assert property (@(posedge clk) disable iff (!rstN)
    (enable && rangeMode && holdQ && strobe.secHit) |=> (matchOut && !holdQ));

  a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!matchOut && !priNotify && !secNotify && !holdQ));

  a_r9_pri_notify_src: assert property (@(posedge clk) disable iff (!rstN)
    priNotify |-> ($past(priSel) == 2'd0 && $past(priNotifyEn)));

  a_r9_sec_notify_src: assert property (@(posedge clk) disable iff (!rstN)
    secNotify |-> ($past(secSel) == 2'd0 && $past(secNotifyEn)));

endmodule

// File: rtl/trace_addr_cmp.sv
module trace_addr_cmp #(
  parameter int IADDR_W = 32,
  parameter int CTX_W   = 24,
  parameter int TVAL_W  = 32,
  parameter int DADDR_W = 32,
  localparam int WIDE1   = (IADDR_W > CTX_W) ? IADDR_W : CTX_W,
  localparam int MATCH_W = (WIDE1 > DADDR_W) ? WIDE1 : DADDR_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [1:0]         priSel,
  input  logic [1:0]         secSel,
  input  logic [2:0]         priFunc,
  input  logic [2:0]         secFunc,
  input  logic [1:0]         matchMode,
  input  logic [MATCH_W-1:0] priValue,
  input  logic [MATCH_W-1:0] secValue,
  input  logic               priNotifyEn,
  input  logic               secNotifyEn,
  input  logic [IADDR_W-1:0] iaddr,
  input  logic [CTX_W-1:0]   ctxIn,
  input  logic [TVAL_W-1:0]  tvalIn,
  input  logic [DADDR_W-1:0] daddr,
  output logic               matchOut,
  output logic               priNotify,
  output logic               secNotify
);
  import trcmp_pkg::*;

  cmpStrobe_t strobe;

  trcmp_datapath #(
    .IADDR_W (IADDR_W),
    .CTX_W   (CTX_W),
    .TVAL_W  (TVAL_W),
    .DADDR_W (DADDR_W),
    .MATCH_W (MATCH_W)
  ) u_datapath (
    .iaddr    (iaddr),
    .ctxIn    (ctxIn),
    .tvalIn   (tvalIn),
    .daddr    (daddr),
    .priSel   (priSel),
    .secSel   (secSel),
    .priFunc  (priFunc),
    .secFunc  (secFunc),
    .priValue (priValue),
    .secValue (secValue),
    .strobe   (strobe)
  );

  trcmp_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .matchMode   (matchMode),
    .priSel      (priSel),
    .secSel      (secSel),
    .priNotifyEn (priNotifyEn),
    .secNotifyEn (secNotifyEn),
    .strobe      (strobe),
    .matchOut    (matchOut),
    .priNotify   (priNotify),
    .secNotify   (secNotify)
  );

endmodule

// File: tb/trace_addr_cmp_tb_top.sv
module trace_addr_cmp_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  priSel = '0, secSel = '0, matchMode = '0;
  logic [2:0]  priFunc = '0, secFunc = '0;
  logic [31:0] priValue = '0, secValue = '0;
  logic        priNotifyEn = 1'b0, secNotifyEn = 1'b0;
  logic [31:0] iaddr = '0, tvalIn = '0, daddr = '0;
  logic [23:0] ctxIn = '0;
  logic        matchOut, priNotify, secNotify;

  // Shadow configuration, applied only at the driving edge
  logic        cEn = 1'b0;
  logic [1:0]  cPriSel = '0, cSecSel = '0, cMode = '0;
  logic [2:0]  cPriFn = '0, cSecFn = 3'd7;
  logic [31:0] cPriVal = '0, cSecVal = '0;
  logic        cPriNot = 1'b0, cSecNot = 1'b0;
  logic        modelHold = 1'b0;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic  m;
    logic  pn;
    logic  sn;
    string tag;
  } expItem_t;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  trace_addr_cmp dut_i (
    .clk(clk), .rstN(rstN), .enable(enable),
    .priSel(priSel), .secSel(secSel), .priFunc(priFunc), .secFunc(secFunc),
    .matchMode(matchMode), .priValue(priValue), .secValue(secValue),
    .priNotifyEn(priNotifyEn), .secNotifyEn(secNotifyEn),
    .iaddr(iaddr), .ctxIn(ctxIn), .tvalIn(tvalIn), .daddr(daddr),
    .matchOut(matchOut), .priNotify(priNotify), .secNotify(secNotify)
  );

  function automatic logic [31:0] busOf(input logic [1:0] sel, input logic [31:0] ia,
                                        input logic [23:0] cx, input logic [31:0] tv,
                                        input logic [31:0] da);
    case (sel)
      2'd0: return ia;
      2'd1: return {8'h00, cx};
      2'd2: return tv;
      default: return da;
    endcase
  endfunction

  function automatic logic relate(input logic [2:0] f, input logic [31:0] a, input logic [31:0] b);
    case (f)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd2: return a < b;
      3'd3: return a <= b;
      3'd4: return a > b;
      3'd5: return a >= b;
      default: return 1'b1;
    endcase
  endfunction

  task automatic step(input logic [31:0] ia, input logic [23:0] cx,
                      input logic [31:0] tv, input logic [31:0] da, input string tag);
    logic [31:0] mask;
    logic pri, sec, m;
    expItem_t e;
    @(negedge clk);
    enable = cEn; priSel = cPriSel; secSel = cSecSel; matchMode = cMode;
    priFunc = cPriFn; secFunc = cSecFn; priValue = cPriVal; secValue = cSecVal;
    priNotifyEn = cPriNot; secNotifyEn = cSecNot;
    iaddr = ia; ctxIn = cx; tvalIn = tv; daddr = da;
    mask = (cSecFn == 3'd6) ? cSecVal : 32'hFFFF_FFFF;
    pri  = relate(cPriFn, busOf(cPriSel, ia, cx, tv, da) & mask, cPriVal & mask);
    sec  = (cSecFn == 3'd6) ? 1'b1 : relate(cSecFn, busOf(cSecSel, ia, cx, tv, da), cSecVal);
    case (cMode)
      2'd0: m = pri;
      2'd1: m = pri && sec;
      2'd2: m = !(pri && sec);
      default: m = pri || modelHold;
    endcase
    e.m   = cEn && m;
    e.pn  = cEn && cPriNot && pri && (cPriSel == 2'd0);
    e.sn  = cEn && cSecNot && sec && (cSecSel == 2'd0);
    e.tag = tag;
    modelHold = cEn && (cMode == 2'd3) && (pri || modelHold) && !sec;
    expQ.push_back(e);
  endtask

  // Monitor: results are registered one edge after the drive
  initial begin
    expItem_t e;
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        total++;
        if (matchOut !== e.m || priNotify !== e.pn || secNotify !== e.sn) begin
          bad++;
          $display("FAIL %s: got m=%b pn=%b sn=%b expected m=%b pn=%b sn=%b",
                   e.tag, matchOut, priNotify, secNotify, e.m, e.pn, e.sn);
        end
      end
    end
  end

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    enable = 1'b1; priFunc = 3'd7; matchMode = 2'd0;
    @(negedge clk);
    total++;
    if (matchOut !== 1'b0 || priNotify !== 1'b0 || secNotify !== 1'b0) begin
      bad++;
      $display("FAIL R11 reset: got %b%b%b expected 000", matchOut, priNotify, secNotify);
    end
    enable = 1'b0;
    rstN = 1'b1;

    // R5 / R2: mode 0, equality on instruction address
    cEn = 1'b1; cMode = 2'd0; cPriSel = 2'd0; cPriFn = 3'd0; cPriVal = 32'h1000;
    step(32'h1000, 24'h0, 32'h0, 32'h0, "R5 R2 eq hit");
    step(32'h1004, 24'h0, 32'h0, 32'h0, "R5 R2 eq miss");

    // R2: relational codes at the boundary
    for (int f = 1; f <= 5; f++) begin
      cPriFn = 3'(f);
      step(32'h0FFF, 24'h0, 32'h0, 32'h0, "R2 relational below");
      step(32'h1000, 24'h0, 32'h0, 32'h0, "R2 relational equal");
      step(32'h1001, 24'h0, 32'h0, 32'h0, "R2 relational above");
    end
    cPriFn = 3'd2; cPriVal = 32'h8000_0000;
    step(32'h7FFF_FFFF, 24'h0, 32'h0, 32'h0, "R2 unsigned below msb");
    step(32'hFFFF_FFFF, 24'h0, 32'h0, 32'h0, "R2 unsigned msb set");

    // R1: select codes and zero extension
    cPriFn = 3'd0;
    cPriSel = 2'd1; cPriVal = 32'h00AB_CDEF;
    step(32'h00AB_CDEF, 24'hABCDEF, 32'h0, 32'h0, "R1 context hit");
    cPriVal = 32'hFFAB_CDEF;
    step(32'hFFAB_CDEF, 24'hABCDEF, 32'h0, 32'h0, "R1 context zero-extended");
    cPriSel = 2'd2; cPriVal = 32'h5555_0000;
    step(32'h0, 24'h0, 32'h5555_0000, 32'h1, "R1 trap value hit");
    step(32'h5555_0000, 24'h0, 32'h1, 32'h5555_0000, "R1 trap value miss");
    cPriSel = 2'd3; cPriVal = 32'h2222_4444;
    step(32'h0, 24'h0, 32'h0, 32'h2222_4444, "R1 data address hit");
    step(32'h2222_4444, 24'h0, 32'h2222_4444, 32'h0, "R1 data address miss");

    // R3: unconditional codes
    cPriSel = 2'd0; cPriVal = 32'h1;
    cPriFn = 3'd6; step(32'h9, 24'h0, 32'h0, 32'h0, "R3 primary code 6");
    cPriFn = 3'd7; step(32'h9, 24'h0, 32'h0, 32'h0, "R3 primary code 7");
    cMode = 2'd1; cSecFn = 3'd7; cSecSel = 2'd3; cSecVal = 32'h5;
    step(32'h9, 24'h0, 32'h0, 32'h0, "R3 secondary code 7");

    // R6 / R7: both and nand over all four hit combinations
    cPriFn = 3'd0; cPriVal = 32'h100; cSecFn = 3'd0; cSecVal = 32'h200;
    for (int md = 1; md <= 2; md++) begin
      cMode = 2'(md);
      step(32'h100, 24'h0, 32'h0, 32'h200, md == 1 ? "R6 both hit" : "R7 both hit");
      step(32'h100, 24'h0, 32'h0, 32'h201, md == 1 ? "R6 pri only" : "R7 pri only");
      step(32'h101, 24'h0, 32'h0, 32'h200, md == 1 ? "R6 sec only" : "R7 sec only");
      step(32'h101, 24'h0, 32'h0, 32'h201, md == 1 ? "R6 none" : "R7 none");
    end

    // R4: secondary as mask
    cMode = 2'd1; cSecFn = 3'd6; cSecVal = 32'hFF00_FF00; cPriVal = 32'h1200_3400;
    step(32'h12AB_34CD, 24'h0, 32'h0, 32'h0, "R4 masked hit");
    step(32'h13AB_34CD, 24'h0, 32'h0, 32'h0, "R4 masked miss");
    cPriFn = 3'd4; cPriVal = 32'h1200_34FF;
    step(32'h1200_35FF, 24'h0, 32'h0, 32'h0, "R4 masked greater");

    // R8: range mode hold
    cMode = 2'd3; cPriFn = 3'd0; cPriVal = 32'h100; cSecFn = 3'd0; cSecSel = 2'd0; cSecVal = 32'h200;
    step(32'h050, 24'h0, 32'h0, 32'h0, "R8 idle");
    step(32'h100, 24'h0, 32'h0, 32'h0, "R8 primary start");
    step(32'h150, 24'h0, 32'h0, 32'h0, "R8 held");
    step(32'h200, 24'h0, 32'h0, 32'h0, "R8 secondary cycle still set");
    step(32'h250, 24'h0, 32'h0, 32'h0, "R8 dropped after secondary");

    // R10: disable clears the hold
    step(32'h100, 24'h0, 32'h0, 32'h0, "R10 set hold");
    cEn = 1'b0;
    step(32'h100, 24'h0, 32'h0, 32'h0, "R10 disabled low");
    cEn = 1'b1;
    step(32'h150, 24'h0, 32'h0, 32'h0, "R10 hold cleared");

    // R9: notify strobes
    cMode = 2'd0; cPriNot = 1'b1; cSecNot = 1'b1;
    step(32'h100, 24'h0, 32'h0, 32'h0, "R9 pri notify");
    step(32'h200, 24'h0, 32'h0, 32'h0, "R9 sec notify");
    cPriSel = 2'd3; cSecSel = 2'd3;
    step(32'h0, 24'h0, 32'h0, 32'h100, "R9 pri notify blocked by select");
    step(32'h0, 24'h0, 32'h0, 32'h200, "R9 sec notify blocked by select");
    cPriSel = 2'd0; cSecSel = 2'd0; cPriNot = 1'b0;
    step(32'h100, 24'h0, 32'h0, 32'h0, "R9 pri notify disabled");

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule